// File: doc/BRIEF.md
# Switchable-Depth Arithmetic Pipeline

This block is a fixed arithmetic datapath of eight combinational steps. A register follows each step. The registers that follow the first, third, fifth and seventh steps can each be bypassed at run time by a multiplexer, so the same logic runs in one of two ways. With every register active it is a deep pipeline whose latency suits a fast clock. With the alternate registers bypassed it is a shallow pipeline of half the depth, where each pair of neighbouring steps settles within one cycle. That pairing suits a halved clock and keeps the completion time of each result the same.

A valid flag travels with every word through the same registers and multiplexers as the data. A new word can enter on every cycle, and nothing at the edge of the block can stall it. A level input selects the depth. The block adopts a new depth only in a cycle in which it holds no valid word and none is entering. While it is busy, a different request has no effect, and a request that is withdrawn before the block drains leaves the depth as it was.

Top module: `flexdepth_pipe`

## Requirements
- R1: A synchronous active-high `rst` clears every valid flag and selects deep mode. On the cycle after reset, `busy`, `out_valid` and `shallow_mode` are all low.
- R2: Step k (k = 0..7) adds the constant ((2k+1)*257) mod 2^WIDTH to its input and then rotates the sum left by one bit. `out_data` is the result of steps 0 to 7 applied in order to the accepted `in_data`.
- R3: In deep mode (`shallow_mode` low), a word accepted at a clock edge appears on `out_valid`/`out_data` exactly 8 clock edges later.
- R4: In shallow mode (`shallow_mode` high), the registers after steps 0, 2, 4 and 6 are bypassed. A word accepted at a clock edge appears exactly 4 clock edges later.
- R5: A given input produces the same `out_data` in both modes. Only the latency differs.
- R6: `out_valid` is high exactly on the cycles that carry an accepted word. It never rises without a matching earlier input.
- R7: `busy` is high on a cycle exactly when at least one stage register holds a valid word, the bypassed ones included.
- R8: At a clock edge, `shallow_mode` takes the value of `mode_sel` only when `busy` is low and `in_valid` is low. Otherwise it keeps its value, so a request raised and dropped while busy has no effect.
- R9: A word is accepted on every clock edge at which `in_valid` is high, including on back-to-back cycles. The block has no stall.
- R10: When a depth request and an input word fall on the same idle cycle, the word is accepted and the depth is kept. The new depth applies only after that word has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Requested depth: 1 shallow, 0 deep |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | WIDTH | Input word |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | WIDTH | Result of the eight steps |
| busy | output | 1 | Some stage register holds a valid word |
| shallow_mode | output | 1 | Depth in force: 1 shallow, 0 deep |

## Verification
Two events can fall on the same clock edge: a change of depth and the acceptance of a word. The bench provokes this by raising `mode_sel` and `in_valid` together on an idle cycle. It also raises and drops `mode_sel` while words are in flight. A cycle-by-cycle model in the bench schedules each expected result at 8 or 4 edges after its acceptance, according to the depth the model holds at that moment. The model changes depth only on idle edges with no input. Every cycle, it compares `out_valid`, `out_data`, `busy` and `shallow_mode` against the design, so a word lost or a depth switched early shows up as a mismatch.

// File: rtl/flexdepth_pipe.sv
module flexdepth_pipe #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             busy,
  output logic             shallow_mode
);

  localparam int LAST = STAGES - 1;

  function automatic logic [WIDTH-1:0] step_fn(input int k, input logic [WIDTH-1:0] x);
    logic [WIDTH-1:0] t;
    t = x + WIDTH'((2 * k + 1) * 257);
    return {t[WIDTH-2:0], t[WIDTH-1]};
  endfunction

  logic              shallow_q;
  logic [STAGES-1:0] v_all;

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    logic [WIDTH-1:0] din, dout, dreg, bd;
    logic             vin, vreg, bv;

    if (k == 0) begin : g_head
      assign din = in_data;
      assign vin = in_valid;
    end else begin : g_link
      assign din = g_st[k-1].bd;
      assign vin = g_st[k-1].bv;
    end

    assign dout = step_fn(k, din);

    always_ff @(posedge clk) begin
      dreg <= dout;
      if (rst) vreg <= 1'b0;
      else     vreg <= vin;
    end

    if (k % 2 == 0 && k != LAST) begin : g_byp
      assign bd = shallow_q ? dout : dreg;
      assign bv = shallow_q ? vin  : vreg;
    end else begin : g_fix
      assign bd = dreg;
      assign bv = vreg;
    end

    assign v_all[k] = vreg;
  end

  assign busy         = |v_all;
  assign out_valid    = g_st[LAST].vreg;
  assign out_data     = g_st[LAST].dreg;
  assign shallow_mode = shallow_q;

  always_ff @(posedge clk) begin
    if (rst)                     shallow_q <= 1'b0;
    else if (!busy && !in_valid) shallow_q <= mode_sel;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !out_valid && !shallow_mode));

  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(shallow_mode));

  a_r10_hold_on_input: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> $stable(shallow_mode));

  a_r4_shallow_pair_entry: assert property (@(posedge clk) disable iff (rst)
    (shallow_q && in_valid) |=> g_st[1].vreg);

  a_r3_deep_last_hop: assert property (@(posedge clk) disable iff (rst)
    (!shallow_q && g_st[LAST-1].vreg) |=> out_valid);

  a_r6_no_phantom: assert property (@(posedge clk) disable iff (rst)
    (!busy && !in_valid) |=> !busy);

endmodule

// File: tb/flexdepth_pipe_tb.sv
module flexdepth_pipe_tb_top;
  localparam int W = 16;
  localparam int N = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_sel = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid, busy, shallow_mode;
  logic [W-1:0] out_data;

  flexdepth_pipe #(.WIDTH(W), .STAGES(8)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .busy(busy), .shallow_mode(shallow_mode)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int maxdone = -1;
  logic model_mode = 1'b0;
  logic         ev [N];
  logic [W-1:0] ed [N];
  int           el [N];

  function automatic logic [W-1:0] ref_fn(input logic [W-1:0] x);
    logic [W-1:0] y;
    y = x;
    for (int k = 0; k < 8; k++) begin
      y = y + W'((2 * k + 1) * 257);
      y = {y[W-2:0], y[W-1]};
    end
    return y;
  endfunction

  initial for (int i = 0; i < N; i++) begin ev[i] = 1'b0; ed[i] = '0; el[i] = 0; end

  task automatic step(input logic r, input logic v, input logic [W-1:0] d, input logic m);
    logic bz;
    int lat;
    @(negedge clk);
    bz = (maxdone >= cyc);
    checks++;
    if (out_valid !== ev[cyc]) begin
      errors++;
      $display("FAIL %s out_valid cyc=%0d actual=%b expected=%b",
               (el[cyc] == 4) ? "R4" : ((el[cyc] == 8) ? "R3" : "R6"), cyc, out_valid, ev[cyc]);
    end
    if (ev[cyc]) begin
      checks++;
      if (out_data !== ed[cyc]) begin
        errors++;
        $display("FAIL %s out_data cyc=%0d actual=%h expected=%h",
                 (el[cyc] == 4) ? "R5" : "R2", cyc, out_data, ed[cyc]);
      end
    end
    checks++;
    if (busy !== bz) begin
      errors++;
      $display("FAIL R7 busy cyc=%0d actual=%b expected=%b", cyc, busy, bz);
    end
    checks++;
    if (shallow_mode !== model_mode) begin
      errors++;
      $display("FAIL R8 shallow_mode cyc=%0d actual=%b expected=%b", cyc, shallow_mode, model_mode);
    end
    rst = r; in_valid = v; in_data = d; mode_sel = m;
    if (!r && v) begin
      lat = model_mode ? 4 : 8;
      if (cyc + lat < N) begin
        ev[cyc + lat] = 1'b1;
        ed[cyc + lat] = ref_fn(d);
        el[cyc + lat] = lat;
      end
      maxdone = cyc + lat;
    end
    if (r) model_mode = 1'b0;
    else if (!bz && !v) model_mode = m;
    cyc++;
  endtask

  task automatic idle(input int n, input logic m);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, m);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, 1'b0);
    step(1'b0, 1'b0, '0, 1'b0);
    checks++;
    if (busy !== 1'b0 || out_valid !== 1'b0 || shallow_mode !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset actual=%b%b%b expected=000", busy, out_valid, shallow_mode);
    end
    // R2 R3 R9: deep, back-to-back sweep
    for (int i = 0; i < 768; i++) step(1'b0, 1'b1, W'(i * 53) ^ 16'hA5A5, 1'b0);
    // R6: deep with gaps
    for (int i = 0; i < 200; i++) step(1'b0, (i % 3) != 0, W'(i * 771), 1'b0);
    idle(12, 1'b0);
    // R8: request raised and dropped while busy is ignored
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, W'(16'hF000 + i), 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, 1'b1);
    idle(12, 1'b0);
    checks++;
    if (shallow_mode !== 1'b0) begin
      errors++;
      $display("FAIL R8 blocked request actual=%b expected=0", shallow_mode);
    end
    // R10: request and input on the same idle cycle
    step(1'b0, 1'b1, 16'h1234, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, W'(16'h4321 + i), 1'b1);
    idle(12, 1'b1);
    checks++;
    if (shallow_mode !== 1'b1) begin
      errors++;
      $display("FAIL R10 mode after drain actual=%b expected=1", shallow_mode);
    end
    // R4 R5: shallow sweep, same data as the deep sweep
    for (int i = 0; i < 768; i++) step(1'b0, 1'b1, W'(i * 53) ^ 16'hA5A5, 1'b1);
    for (int i = 0; i < 200; i++) step(1'b0, (i % 4) != 1, W'(i * 12345), 1'b1);
    idle(8, 1'b1);
    // single word, shallow latency R4
    step(1'b0, 1'b1, 16'hFFFF, 1'b1);
    idle(8, 1'b1);
    // back to deep R3
    idle(4, 1'b0);
    step(1'b0, 1'b1, 16'hFFFF, 1'b0);
    idle(12, 1'b0);
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, W'(i * 999), 1'b0);
    idle(12, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule